// File: doc/BRIEF.md
# USB Low-Speed Serial Transmitter

This block sends one low-speed USB packet on the D+/D- pair. A frame is started by a single-cycle `start` together with a byte count that includes the leading sync byte. The transmitter takes the bus, holds it in idle J for one bit time, and sends every byte least significant bit first. The line is NRZI coded, and a stuffed zero follows every run of six ones. It closes the frame with end-of-packet and then lets go of the bus. Each bit lasts `BIT_CLKS` clock cycles, eight by default.

Bytes come from a simple source. The source reports `src_rdy` and presents `src_data`. The transmitter consumes a byte with a one-cycle `src_take`. It fetches the sync byte when the frame starts. It fetches each further byte at the moment the previous one moves into the shift register, so every byte is buffered one byte time ahead. If the source is empty at a fetch, the block flags `underrun` and sends 0x00 in place of that byte.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset the block is idle. `busy`, `done` and `usb_oe` are low, and `usb_dp` and `usb_dm` are both 0.
- R2: In the cycle after `start` is accepted, `busy` and `usb_oe` go high and the line shows J (`usb_dp`=0, `usb_dm`=1) for one full bit time before the first data bit.
- R3: Every line state lasts exactly `BIT_CLKS` (8) clock cycles. The outputs change only at bit boundaries.
- R4: Bytes are sent LSB first, with the first byte being the sync byte, and `byte_cnt` counts the sync byte. NRZI coding is used: a 0 bit toggles the line between J and K (K is `usb_dp`=1, `usb_dm`=0), and a 1 bit keeps the line state.
- R5: After six consecutive 1 bits, one extra toggle is sent as a stuffed 0. The stuffed bit lasts a full bit time and delays the following bits. The run of ones carries across byte boundaries and also counts before end-of-packet.
- R6: After the last bit, both lines are low (SE0) for two bit times, then J for one bit time. Then `usb_oe` drops, both lines return to 0, `busy` falls and `done` pulses high for exactly one cycle.
- R7: `src_take` pulses once for every byte of the frame. The first pulse comes when the start is accepted. Each later pulse comes when the previous byte is loaded for shifting. The number of takes equals `byte_cnt` when the source has enough bytes.
- R8: If a byte is fetched while `src_rdy` is low, `underrun` pulses for one cycle, there is no `src_take`, and the byte is sent as 0x00.
- R9: A `start` while `busy` is high is ignored. The frame in progress and the byte fetches are unaffected, and no second frame follows.
- R10: With `byte_cnt` = 0 the frame is lead J, two bits of SE0, one bit of J, with no fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a frame; sampled only while idle |
| byte_cnt | input | CNT_W | Bytes in the frame, sync byte included |
| busy | output | 1 | High from the cycle after start until the bus is released |
| done | output | 1 | One-cycle pulse when the bus is released |
| src_rdy | input | 1 | The source has a byte available |
| src_data | input | 8 | The byte offered by the source |
| src_take | output | 1 | Consumes `src_data` in this cycle |
| underrun | output | 1 | A fetch found the source empty; 0x00 is sent instead |
| usb_dp | output | 1 | D+ line level |
| usb_dm | output | 1 | D- line level |
| usb_oe | output | 1 | Output enable for both lines |

## Verification
The assertions assume that `src_rdy` does not depend combinationally on `src_take`, and that `start` and `byte_cnt` settle between clock edges. The stimulus keeps to this. The bench drives all inputs at the falling edge. It derives `src_rdy` from its own read index, which moves only at a rising edge. It keeps every frame under sixteen bytes, so each run of ones and each stuffing point can be predicted from the byte list alone.

// File: rtl/usb_ls_tx_pkg.sv
// Package: shared frame states and coding constants for the low-speed transmitter.
package usb_ls_tx_pkg;
    typedef enum logic [2:0] {
        TX_IDLE,
        TX_LEAD_J,
        TX_DATA,
        TX_EOP,
        TX_TAIL_J
    } tx_state_e;

    localparam int STUFF_RUN = 6;  // ones in a row before a forced toggle
    localparam int BYTE_W    = 8;
    localparam int EOP_BITS  = 2;  // SE0 length in bit times
endpackage

// File: rtl/usb_ls_bit_timer.sv
// Bit timer: counts clock cycles within one bit slot while a frame runs.
// Assumes: run stays high for the whole frame and drops only after a slot end.
module usb_ls_bit_timer #(
    parameter int BIT_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic bit_end
);
    localparam int PH_W = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_CLKS - 1);

    logic [PH_W-1:0] phase;

    // Phase counter: wraps at the last cycle of each slot, held at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            phase <= '0;
        else if (phase == PH_LAST)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    assign bit_end = run && (phase == PH_LAST);

    // R3: inside a slot the phase advances by exactly one each cycle.
    p_phase_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && phase != PH_LAST) |=> (phase == $past(phase) + 1'b1));
endmodule

// File: rtl/usb_ls_byte_feeder.sv
// Byte feeder: one-byte holding register filled from the source on each fetch.
// Assumes: src_rdy does not depend on src_take in the same cycle.
module usb_ls_byte_feeder #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch,
    input  logic              src_rdy,
    input  logic [BYTE_W-1:0] src_data,
    output logic              src_take,
    output logic              underrun,
    output logic [BYTE_W-1:0] hold
);
    assign src_take = fetch && src_rdy;
    assign underrun = fetch && !src_rdy;

    // Holding register: captures the source byte, or zero when the source is empty.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold <= '0;
        else if (fetch)
            hold <= src_rdy ? src_data : '0;
    end

    // R8: a starved fetch leaves a zero byte to be sent.
    p_zero_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> (hold == '0));
endmodule

// File: rtl/usb_ls_nrzi_enc.sv
// NRZI encoder with bit stuffing: keeps the line polarity and the run of ones.
// Assumes: step is raised once per bit slot, and clear at frame start.
module usb_ls_nrzi_enc #(
    parameter int STUFF_RUN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic bit_val,
    output logic line_k,
    output logic stuff_due
);
    localparam int RUN_W = $clog2(STUFF_RUN + 1);

    logic [RUN_W-1:0] ones;

    assign stuff_due = (ones == RUN_W'(STUFF_RUN));

    // Line state and run length: a zero or a stuffed bit toggles, a one extends the run.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            line_k <= 1'b0;
            ones   <= '0;
        end else if (step) begin
            if (stuff_due || !bit_val) begin
                line_k <= ~line_k;
                ones   <= '0;
            end else begin
                ones <= ones + 1'b1;
            end
        end
    end

    // R5: the run of ones never passes the stuffing limit.
    p_run_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ones <= RUN_W'(STUFF_RUN));
    // R5: a stuffed slot always flips the line.
    p_stuff_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && stuff_due && !clear) |=> (line_k != $past(line_k)));
endmodule

// File: rtl/usb_ls_tx.sv
// Low-speed USB transmitter top: frame sequencing, byte shifting and line drive.
// Assumes: byte_cnt counts the sync byte; the source supplies the sync byte first.
module usb_ls_tx #(
    parameter int CNT_W    = 8,
    parameter int BIT_CLKS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_cnt,
    output logic             busy,
    output logic             done,
    input  logic             src_rdy,
    input  logic [7:0]       src_data,
    output logic             src_take,
    output logic             underrun,
    output logic             usb_dp,
    output logic             usb_dm,
    output logic             usb_oe
);
    import usb_ls_tx_pkg::*;

    localparam int SH_W  = BYTE_W - 1;
    localparam int SC_W  = $clog2(BYTE_W);
    localparam int EOP_W = $clog2(EOP_BITS);

    tx_state_e         state;
    logic [CNT_W-1:0]  bytes_left;
    logic [SH_W-1:0]   sh;
    logic [SC_W-1:0]   sh_cnt;
    logic [EOP_W-1:0]  eop_idx;
    logic              done_q;

    logic              bit_end, line_k, stuff_due;
    logic [BYTE_W-1:0] hold;
    logic              accept, adv, have_bits, have_byte;
    logic              load, shift_now, go_eop, enc_step, bit_val, fetch;

    // Slot decisions: stuff first, then the current byte, then a new byte, else end of packet.
    always_comb begin
        accept    = (state == TX_IDLE) && start;
        adv       = bit_end && (state == TX_LEAD_J || state == TX_DATA);
        have_bits = (sh_cnt != '0);
        have_byte = (bytes_left != '0);
        shift_now = adv && !stuff_due && have_bits;
        load      = adv && !stuff_due && !have_bits && have_byte;
        go_eop    = adv && !stuff_due && !have_bits && !have_byte;
        enc_step  = adv && !go_eop;
        bit_val   = have_bits ? sh[0] : hold[0];
        fetch     = (accept && byte_cnt != '0) ||
                    (load && bytes_left > CNT_W'(1));
    end

    usb_ls_bit_timer #(.BIT_CLKS(BIT_CLKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state != TX_IDLE),
        .bit_end (bit_end)
    );

    usb_ls_byte_feeder #(.BYTE_W(BYTE_W)) u_feeder (
        .clk      (clk),
        .rst_n    (rst_n),
        .fetch    (fetch),
        .src_rdy  (src_rdy),
        .src_data (src_data),
        .src_take (src_take),
        .underrun (underrun),
        .hold     (hold)
    );

    usb_ls_nrzi_enc #(.STUFF_RUN(STUFF_RUN)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .step      (enc_step),
        .bit_val   (bit_val),
        .line_k    (line_k),
        .stuff_due (stuff_due)
    );

    // Frame sequencer: lead J, data slots, two SE0 slots, tail J, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= TX_IDLE;
            bytes_left <= '0;
            sh         <= '0;
            sh_cnt     <= '0;
            eop_idx    <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                TX_IDLE: begin
                    if (start) begin
                        state      <= TX_LEAD_J;
                        bytes_left <= byte_cnt;
                        sh_cnt     <= '0;
                    end
                end
                TX_LEAD_J, TX_DATA: begin
                    if (go_eop) begin
                        state   <= TX_EOP;
                        eop_idx <= '0;
                    end else if (adv) begin
                        state <= TX_DATA;
                        if (load) begin
                            sh         <= hold[BYTE_W-1:1];
                            sh_cnt     <= SC_W'(BYTE_W - 1);
                            bytes_left <= bytes_left - CNT_W'(1);
                        end else if (shift_now) begin
                            sh     <= {1'b0, sh[SH_W-1:1]};
                            sh_cnt <= sh_cnt - SC_W'(1);
                        end
                    end
                end
                TX_EOP: begin
                    if (bit_end) begin
                        if (eop_idx == EOP_W'(EOP_BITS - 1))
                            state <= TX_TAIL_J;
                        else
                            eop_idx <= eop_idx + 1'b1;
                    end
                end
                TX_TAIL_J: begin
                    if (bit_end) begin
                        state  <= TX_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // Line drive: J around the frame, NRZI level during data, SE0 at the end, zero when released.
    always_comb begin
        usb_oe = (state != TX_IDLE);
        case (state)
            TX_DATA:              begin usb_dp = line_k; usb_dm = ~line_k; end
            TX_LEAD_J, TX_TAIL_J: begin usb_dp = 1'b0;   usb_dm = 1'b1;    end
            default:              begin usb_dp = 1'b0;   usb_dm = 1'b0;    end
        endcase
    end

    assign busy = (state != TX_IDLE);
    assign done = done_q;

    // R2: the first driven state of a frame is idle J.
    p_lead_j_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (usb_oe && usb_dm && !usb_dp));
    // R3: no line change inside a slot.
    p_slot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TX_IDLE && !bit_end) |=> $stable({usb_dp, usb_dm, usb_oe}));
    // R4: both lines are never high together while driven.
    p_no_se1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        usb_oe |-> !(usb_dp && usb_dm));
    // R6: the done pulse coincides with the release of the bus.
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && !usb_oe && !usb_dp && !usb_dm));
    // R9: a frame keeps running until its tail J ends.
    p_keep_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(state == TX_TAIL_J && bit_end)) |=> busy);
endmodule

// File: tb/test_usb_ls_tx.sv
module test_usb_ls_tx;
    localparam int J_C = 3'b101;
    localparam int K_C = 3'b110;
    localparam int SE0_C = 3'b100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] byte_cnt = 8'd0;
    logic       busy, done, src_take, underrun, usb_dp, usb_dm, usb_oe;
    logic       src_rdy;
    logic [7:0] src_data;

    logic [7:0] fr [0:15];
    int src_len = 0;
    int src_base = 0;
    int src_idx = 0;
    int take_cnt = 0;
    int urun_cnt = 0;
    int n_run = 0;
    int n_fail = 0;
    int exp_sym [0:1023];
    int n_sym;

    always #5 clk = ~clk;

    assign src_rdy  = (src_idx - src_base) < src_len;
    assign src_data = src_rdy ? fr[(src_idx - src_base) & 15] : 8'h00;

    usb_ls_tx i_usb_ls_tx (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_cnt(byte_cnt),
        .busy(busy), .done(done), .src_rdy(src_rdy), .src_data(src_data),
        .src_take(src_take), .underrun(underrun),
        .usb_dp(usb_dp), .usb_dm(usb_dm), .usb_oe(usb_oe)
    );

    // Source model: advances its read index on each take, counts starved fetches.
    always @(posedge clk) begin
        if (src_take) begin
            src_idx  <= src_idx + 1;
            take_cnt <= take_cnt + 1;
        end
        if (underrun) urun_cnt <= urun_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected slot sequence from the byte list: NRZI, stuffing, end of packet.
    task automatic build_expected(input int cnt);
        int k = 0;
        int ones = 0;
        n_sym = 0;
        exp_sym[n_sym++] = J_C;
        for (int b = 0; b < cnt; b++) begin
            logic [7:0] v = (b < src_len) ? fr[b] : 8'h00;
            for (int i = 0; i < 8; i++) begin
                if (!v[i]) begin k ^= 1; ones = 0; end
                else ones++;
                exp_sym[n_sym++] = k ? K_C : J_C;
                if (ones == 6) begin
                    k ^= 1; ones = 0;
                    exp_sym[n_sym++] = k ? K_C : J_C;
                end
            end
        end
        exp_sym[n_sym++] = SE0_C;
        exp_sym[n_sym++] = SE0_C;
        exp_sym[n_sym++] = J_C;
    endtask

    task automatic run_frame(input int cnt, input int inj, input string req);
        int bad_i = -1;
        int bad_a = 0;
        int bad_busy = 0;
        int t0, u0;
        int exp_take, exp_urun;
        build_expected(cnt);
        t0 = take_cnt; u0 = urun_cnt;
        @(negedge clk);
        src_base = src_idx;
        byte_cnt = 8'(cnt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < n_sym; i++) begin
            if (i > 0) begin
                if (i == inj) begin
                    start = 1'b1; byte_cnt = 8'd3;
                    @(negedge clk);
                    start = 1'b0;
                    repeat (7) @(negedge clk);
                end else begin
                    repeat (8) @(negedge clk);
                end
            end
            if (bad_i < 0 && {usb_oe, usb_dp, usb_dm} != 3'(exp_sym[i])) begin
                bad_i = i; bad_a = {usb_oe, usb_dp, usb_dm};
            end
            if (!busy) bad_busy++;
        end
        chk(bad_i < 0, req, "line slot sequence (oe,dp,dm)", bad_a,
            (bad_i < 0) ? 0 : exp_sym[bad_i]);
        chk(bad_busy == 0, "R2", "busy low inside frame, count", bad_busy, 0);
        repeat (4) @(negedge clk);
        chk(done && !busy && !usb_oe && !usb_dp && !usb_dm, "R6",
            "release {done,busy,oe,dp,dm}",
            {done, busy, usb_oe, usb_dp, usb_dm}, 5'b10000);
        @(negedge clk);
        chk(!done && !busy, "R6", "done pulse width {done,busy}",
            {done, busy}, 0);
        exp_take = (cnt < src_len) ? cnt : src_len;
        exp_urun = (cnt > src_len) ? cnt - src_len : 0;
        chk(take_cnt - t0 == exp_take, "R7", "byte takes", take_cnt - t0, exp_take);
        chk(urun_cnt - u0 == exp_urun, "R8", "underruns", urun_cnt - u0, exp_urun);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        chk(!busy && !done && !usb_oe && !usb_dp && !usb_dm, "R1",
            "reset {busy,done,oe,dp,dm}", {busy, done, usb_oe, usb_dp, usb_dm}, 0);

        // R4: sync plus mixed bytes
        fr[0] = 8'h80; fr[1] = 8'hA5; fr[2] = 8'h3C; src_len = 3;
        run_frame(3, -1, "R4");

        // R5: long runs of ones across byte boundaries and into end of packet
        fr[0] = 8'h80; fr[1] = 8'hFF; fr[2] = 8'hFF; fr[3] = 8'hFF; src_len = 4;
        run_frame(4, -1, "R5");

        // R5: run of exactly six ending a byte, continued in next
        fr[0] = 8'h80; fr[1] = 8'hFC; fr[2] = 8'h01; src_len = 3;
        run_frame(3, -1, "R5");

        // R4: all zeros toggle every slot
        fr[0] = 8'h80; fr[1] = 8'h00; src_len = 2;
        run_frame(2, -1, "R4");

        // R4: sync byte only
        fr[0] = 8'h80; src_len = 1;
        run_frame(1, -1, "R4");

        // R10: empty frame
        src_len = 0;
        run_frame(0, -1, "R10");

        // R8: source runs dry after two bytes
        fr[0] = 8'h80; fr[1] = 8'h5A; src_len = 2;
        run_frame(4, -1, "R8");

        // R9: start pulse in the middle of a frame
        fr[0] = 8'h80; fr[1] = 8'hC3; fr[2] = 8'h7E; src_len = 3;
        run_frame(3, 12, "R9");
        repeat (20) @(negedge clk);
        chk(!busy && !usb_oe, "R9", "no frame after ignored start {busy,oe}",
            {busy, usb_oe}, 0);

        // R3: random frames, bit timing checked through mid-slot sampling
        for (int f = 0; f < 6; f++) begin
            int c = 1 + ($urandom % 6);
            fr[0] = 8'h80;
            for (int b = 1; b < 16; b++) fr[b] = 8'($urandom);
            src_len = c;
            run_frame(c, -1, "R3");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule